// File: doc/BRIEF.md
# Second-Order Masked AND Gate (Three Shares)

This block computes the bitwise AND of two W-bit operands without ever putting both shares of an operand into the same combinational cone ahead of a register. Each operand arrives as three Boolean shares, and the operand's value is the XOR of its three shares. The output is three shares whose XOR is the AND of the two operands. This is the minimum share count for second-order protection against power analysis. A larger masked datapath, such as an S-box, uses the gate as one of its nonlinear steps. The caller splits the operands into shares, supplies the fresh randomness, and recombines the result when the unmasked value is needed.

The gate works in layers. First it forms the nine cross products of one a-share with one b-share. It then refreshes each product with two adjacent words taken from a ring of nine random words and stores the nine refreshed terms in registers. Finally, an XOR compression after those registers merges the terms back into three shares. Each product sees only one share of each operand, and shares are merged only after the register layer. Glitches in the combinational logic therefore cannot combine all shares of a secret.

Top module: `masked_and3`

## Requirements
- R1: While `rst_n` is low, and on the first sampling after it is released, `out_valid` is 0 and all three output shares are 0.
- R2: One clock edge after a cycle with `in_valid` high, `c_sh0 ^ c_sh1 ^ c_sh2` equals `(a_sh0 ^ a_sh1 ^ a_sh2) & (b_sh0 ^ b_sh1 ^ b_sh2)`, bit by bit, for any values of `rnd`.
- R3: `out_valid` equals `in_valid` delayed by exactly one clock edge.
- R4: Let random word k be `rnd[k*W +: W]`, for k = 0..8, and let B = `b_sh0 ^ b_sh1 ^ b_sh2`. After a valid cycle, the output shares are `c_sh0 = a_sh0 & B ^ r2 ^ r8`, `c_sh1 = a_sh1 & B ^ r5 ^ r2` and `c_sh2 = a_sh2 & B ^ r8 ^ r5`. These values follow from refreshing term k = 3i+j (product a_i & b_j) with words k and (k+8) mod 9, and from compressing terms 3m, 3m+1 and 3m+2 into share m.
- R5: In a cycle with `in_valid` low, the output shares keep their previous values, whatever is on the share and random inputs.
- R6: With every random word at zero, output share m equals `a_sh{m} & B`.
- R7: The random words with index k mod 3 other than 2 (words 0, 1, 3, 4, 6 and 7) have no effect on the output shares.
- R8: Every one of the nine products combines exactly one share of a with exactly one share of b before it reaches a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input shares and randomness are valid |
| a_sh0 | input | W | Share 0 of operand a |
| a_sh1 | input | W | Share 1 of operand a |
| a_sh2 | input | W | Share 2 of operand a |
| b_sh0 | input | W | Share 0 of operand b |
| b_sh1 | input | W | Share 1 of operand b |
| b_sh2 | input | W | Share 2 of operand b |
| rnd | input | 9*W | Nine fresh random words; word k is bits k*W+W-1 down to k*W |
| out_valid | output | 1 | Output shares are valid |
| c_sh0 | output | W | Share 0 of a AND b |
| c_sh1 | output | W | Share 1 of a AND b |
| c_sh2 | output | W | Share 2 of a AND b |

## Verification
The behaviour hardest to see from the ports is the ring refreshing. Two-thirds of the random words cancel inside the compression, so a wrong ring index or a wrong grouping can still give a correct XOR of the three shares. The stimulus therefore checks each output share on its own against the closed form of R4. It also runs cycles in which only the cancelling random words change between two identical operand sets, and cycles with all-zero randomness. Together these expose a wiring error that the recombined value would hide.

// File: rtl/masked_and3.sv
module masked_and3 #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [W-1:0]   a_sh0,
  input  logic [W-1:0]   a_sh1,
  input  logic [W-1:0]   a_sh2,
  input  logic [W-1:0]   b_sh0,
  input  logic [W-1:0]   b_sh1,
  input  logic [W-1:0]   b_sh2,
  input  logic [9*W-1:0] rnd,
  output logic           out_valid,
  output logic [W-1:0]   c_sh0,
  output logic [W-1:0]   c_sh1,
  output logic [W-1:0]   c_sh2
);
  localparam int NS = 3;
  localparam int NT = NS * NS;

  logic [W-1:0] a_in [NS];
  logic [W-1:0] b_in [NS];
  logic [W-1:0] term_d [NT];
  logic [W-1:0] term_q [NT];
  logic [W-1:0] c_out [NS];
  logic         vld_q;

  assign a_in[0] = a_sh0;
  assign a_in[1] = a_sh1;
  assign a_in[2] = a_sh2;
  assign b_in[0] = b_sh0;
  assign b_in[1] = b_sh1;
  assign b_in[2] = b_sh2;

  // R8: one a-share and one b-share per product; ring refresh with words k and k-1
  for (genvar i = 0; i < NS; i++) begin : g_row
    for (genvar j = 0; j < NS; j++) begin : g_col
      localparam int K  = NS * i + j;
      localparam int KP = (K + NT - 1) % NT;
      assign term_d[K] = (a_in[i] & b_in[j]) ^ rnd[K*W +: W] ^ rnd[KP*W +: W];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        term_q[K] <= '0;
        else if (in_valid) term_q[K] <= term_d[K];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= in_valid;
  end

  for (genvar m = 0; m < NS; m++) begin : g_cmp
    assign c_out[m] = term_q[NS*m] ^ term_q[NS*m+1] ^ term_q[NS*m+2];
  end

  assign out_valid = vld_q;
  assign c_sh0 = c_out[0];
  assign c_sh1 = c_out[1];
  assign c_sh2 = c_out[2];

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && c_sh0 == '0 && c_sh1 == '0 && c_sh2 == '0));

  assert_valid_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_valid == $past(in_valid)));

  assert_product_ok_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((c_sh0 ^ c_sh1 ^ c_sh2) ==
      (($past(a_sh0) ^ $past(a_sh1) ^ $past(a_sh2)) &
       ($past(b_sh0) ^ $past(b_sh1) ^ $past(b_sh2)))));

  assert_share0_form_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (c_sh0 == (($past(a_sh0) & ($past(b_sh0) ^ $past(b_sh1) ^ $past(b_sh2)))
                  ^ $past(rnd[2*W +: W]) ^ $past(rnd[8*W +: W]))));

  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(c_sh0) && $stable(c_sh1) && $stable(c_sh2)));
endmodule

// File: tb/masked_and3_tb.sv
`timescale 1ns/1ps
module masked_and3_tb;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic [W-1:0]   a0 = '0, a1 = '0, a2 = '0, b0 = '0, b1 = '0, b2 = '0;
  logic [9*W-1:0] rnd = '0;
  logic           out_valid;
  logic [W-1:0]   c0, c1, c2;

  int checks = 0;
  int errors = 0;

  logic         e_v = 1'b0;
  logic [W-1:0] e0 = '0, e1 = '0, e2 = '0;

  always #2 clk = ~clk;

  masked_and3 #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .a_sh0(a0), .a_sh1(a1), .a_sh2(a2),
    .b_sh0(b0), .b_sh1(b1), .b_sh2(b2),
    .rnd(rnd), .out_valid(out_valid),
    .c_sh0(c0), .c_sh1(c1), .c_sh2(c2)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rw(input int k);
    return rnd[k*W +: W];
  endfunction

  task automatic compare(input string tag);
    chk({tag, " R3 valid"}, {{(W-1){1'b0}}, out_valid}, {{(W-1){1'b0}}, e_v});
    chk({tag, " R4 share0"}, c0, e0);
    chk({tag, " R4 share1"}, c1, e1);
    chk({tag, " R4 share2"}, c2, e2);
  endtask

  // one cycle: drive at negedge, update model, sample at next negedge
  task automatic step(input logic v, input logic [W-1:0] xa0, xa1, xa2, xb0, xb1, xb2,
                      input logic [9*W-1:0] r, input string tag);
    logic [W-1:0] bb;
    in_valid = v; a0 = xa0; a1 = xa1; a2 = xa2; b0 = xb0; b1 = xb1; b2 = xb2; rnd = r;
    bb = xb0 ^ xb1 ^ xb2;
    e_v = v;
    if (v) begin
      e0 = (xa0 & bb) ^ rw(2) ^ rw(8);
      e1 = (xa1 & bb) ^ rw(5) ^ rw(2);
      e2 = (xa2 & bb) ^ rw(8) ^ rw(5);
    end
    @(negedge clk);
    compare(tag);
    if (v) chk({tag, " R2 product"}, c0 ^ c1 ^ c2, (xa0 ^ xa1 ^ xa2) & bb);
  endtask

  function automatic logic [9*W-1:0] rand_rnd();
    logic [9*W-1:0] r;
    for (int k = 0; k < 9; k++) r[k*W +: W] = W'($urandom);
    return r;
  endfunction

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] ra, rb, s0, s1, t0, t1;
    logic [9*W-1:0] r1, r2;
    @(negedge clk); @(negedge clk);
    // R1 during reset
    compare("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after release");

    // R6 zero randomness, directed
    step(1'b1, 8'hF0, 8'h3C, 8'h0F, 8'hAA, 8'h55, 8'hFF, '0, "R6 zero rnd");
    step(1'b1, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF, '0, "R6 b all ones");

    // R5 idle cycles with changing inputs
    step(1'b0, 8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC, rand_rnd(), "R5 idle a");
    step(1'b0, 8'hFE, 8'hDC, 8'hBA, 8'h98, 8'h76, 8'h54, rand_rnd(), "R5 idle b");

    // R7: change only words 0,1,3,4,6,7 between two identical evaluations
    for (int n = 0; n < 20; n++) begin
      logic [W-1:0] h0, h1, h2, p0, p1, p2;
      r1 = rand_rnd(); r2 = rand_rnd();
      for (int k = 2; k < 9; k += 3) r2[k*W +: W] = r1[k*W +: W];
      {h0, h1, h2, p0, p1, p2} = {W'($urandom), W'($urandom), W'($urandom),
                                  W'($urandom), W'($urandom), W'($urandom)};
      step(1'b1, h0, h1, h2, p0, p1, p2, r1, "R7 base");
      s0 = c0; s1 = c1; t0 = c2;
      step(1'b1, h0, h1, h2, p0, p1, p2, r2, "R7 varied");
      chk("R7 share0 unchanged", c0, s0);
      chk("R7 share1 unchanged", c1, s1);
      chk("R7 share2 unchanged", c2, t0);
    end

    // R2/R4 random operands split into random shares, mixed idle cycles
    for (int n = 0; n < 400; n++) begin
      ra = W'($urandom); rb = W'($urandom);
      s0 = W'($urandom); s1 = W'($urandom);
      t0 = W'($urandom); t1 = W'($urandom);
      step(($urandom % 4) != 0, s0, s1, ra ^ s0 ^ s1, t0, t1, rb ^ t0 ^ t1,
           rand_rnd(), "R2 random");
    end

    // R1 reset in the middle of operation
    step(1'b1, 8'hFF, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h00, rand_rnd(), "R4 pre-reset");
    rst_n = 1'b0;
    e_v = 1'b0; e0 = '0; e1 = '0; e2 = '0;
    @(negedge clk);
    compare("R1 mid reset");
    rst_n = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    compare("R1 mid release");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule